// File: doc/BRIEF.md
# Two-Way Read-Allocate Data Cache Controller

This block sits between a CPU load/store port and a next-level memory. It keeps a two-way set-associative cache of 16 KB, with 128 sets and 64-byte lines, over a 32-bit byte address. It holds the tag, valid, dirty and replacement state and the line data. Loads that hit are answered in the next cycle. Stores that hit are merged into the line, which is then marked dirty. No memory traffic is generated at that time.

Only loads allocate. A load miss stalls the CPU and requests the line from memory. The line arrives as eight 64-bit beats and is collected in a side buffer. The requested word is returned once the last beat is in. Then, and only then, a dirty victim is written back while the new line is installed. If the memory flags the fill as noncacheable, the controller drops the writeback and the install, and the victim stays resident. A store that misses leaves the cache untouched and is passed to a separate store port. Misses are handled one at a time.

Top module: `dcache_2way`

## Requirements
- R1: An address splits into byte offset [5:0], set index [12:6] and tag [31:13]. A load hits when the tag matches a valid line in either way of the indexed set. The 64-bit word at offset bits [5:3] is then returned with rsp_valid one cycle after acceptance, cpu_ready stays high, and no memory port is driven.
- R2: On a load miss, mem_rd_valid is raised with mem_rd_addr equal to the request address with bits [5:0] cleared. It is held with a stable address until mem_rd_ready. Eight beats then follow in order, and beat k carries bytes 8k to 8k+7 of the line.
- R3: After a load miss, rsp_rdata carries word [5:3] of the fetched line, with rsp_valid exactly one cycle after the last beat is accepted.
- R4: A store miss raises st_valid once with the full address and data, held until st_ready. The cache contents are unchanged, so a later load of that address misses.
- R5: A store hit replaces the 64-bit word at offset bits [5:3] in place and marks the line dirty. No memory port is driven.
- R6: The victim is an invalid way if one exists, with way 0 chosen when both ways are invalid. Otherwise the victim is the way named by the set's single LRU bit. That bit is set to the other way after every load hit, every store hit and every install.
- R7: For a cacheable fill with a dirty victim, eight writeback beats go out on wb_* only after the last fill beat. Beat k is addressed at the victim's tag and set, plus 8k. The new line replaces the victim.
- R8: When mem_beat_cacheable is low on the last beat, no writeback and no install take place. The victim line and its state are untouched, and the requested word is still returned.
- R9: Reset clears every valid, dirty and LRU bit and leaves all request outputs low with cpu_ready high.
- R10: A clean victim is replaced without any writeback.
- R11: cpu_ready is low from the cycle after a miss is accepted until the controller has finished, including any writeback or install. At most one of mem_rd_valid, wb_valid and st_valid is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU request present |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 64 | Store data |
| cpu_ready | output | 1 | Controller idle; a request is taken when both are high |
| rsp_valid | output | 1 | Load data valid pulse |
| rsp_rdata | output | 64 | Load data |
| mem_rd_valid | output | 1 | Line fetch request |
| mem_rd_addr | output | 32 | Line-aligned fetch address |
| mem_rd_ready | input | 1 | Fetch request accepted |
| mem_beat_valid | input | 1 | Fill beat present |
| mem_beat_data | input | 64 | Fill beat data |
| mem_beat_cacheable | input | 1 | Fill may be cached (sampled on last beat) |
| wb_valid | output | 1 | Victim writeback beat present |
| wb_addr | output | 32 | Writeback beat address |
| wb_data | output | 64 | Writeback beat data |
| wb_ready | input | 1 | Writeback beat accepted |
| st_valid | output | 1 | Forwarded store present |
| st_addr | output | 32 | Forwarded store address |
| st_data | output | 64 | Forwarded store data |
| st_ready | input | 1 | Forwarded store accepted |

## Verification
The assertions assume that the memory sends fill beats only after a fetch request has been accepted, exactly eight per fetch, and never at any other time. They also assume that a request is presented only while cpu_ready is high. The stimulus meets this with a responder that starts beats only after granting mem_rd_ready, and with a CPU driver that waits for cpu_ready before raising req_valid for a single cycle. The writeback and store ports are kept always ready, so each beat is taken in the cycle it is offered.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STORE,
        ST_REQ,
        ST_FILL,
        ST_XFER
    } ctrl_state_e;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
    parameter int SETS  = 128,
    parameter int IDX_W = 7,
    parameter int TAG_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic [1:0]       way_hit,
    output logic             vic_way,
    output logic             vic_dirty,
    output logic [TAG_W-1:0] vic_tag,
    input  logic             lru_we,
    input  logic [IDX_W-1:0] lru_idx,
    input  logic             lru_val,
    input  logic             dirty_we,
    input  logic [IDX_W-1:0] dirty_idx,
    input  logic             dirty_way,
    input  logic             inst_we,
    input  logic [IDX_W-1:0] inst_idx,
    input  logic             inst_way,
    input  logic [TAG_W-1:0] inst_tag
);
    logic [1:0]             way_valid;
    logic [1:0]             way_dirty;
    logic [1:0][TAG_W-1:0]  way_tag;
    logic                   lru_q [SETS];

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [TAG_W-1:0] tag_q   [SETS];
        logic             valid_q [SETS];
        logic             dirty_q [SETS];

        always_ff @(posedge clk) begin
            if (inst_we && inst_way == 1'(w))
                tag_q[inst_idx] <= inst_tag;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < SETS; i++) begin
                    valid_q[i] <= 1'b0;
                    dirty_q[i] <= 1'b0;
                end
            end else begin
                if (inst_we && inst_way == 1'(w)) begin
                    valid_q[inst_idx] <= 1'b1;
                    dirty_q[inst_idx] <= 1'b0;
                end
                if (dirty_we && dirty_way == 1'(w))
                    dirty_q[dirty_idx] <= 1'b1;
            end
        end

        assign way_valid[w] = valid_q[lk_idx];
        assign way_dirty[w] = dirty_q[lk_idx];
        assign way_tag[w]   = tag_q[lk_idx];
        assign way_hit[w]   = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) lru_q[i] <= 1'b0;
        end else if (lru_we) begin
            lru_q[lru_idx] <= lru_val;
        end
    end

    always_comb begin
        if (!way_valid[0])      vic_way = 1'b0;
        else if (!way_valid[1]) vic_way = 1'b1;
        else                    vic_way = lru_q[lk_idx];
        vic_dirty = way_valid[vic_way] && way_dirty[vic_way];
        vic_tag   = way_tag[vic_way];
    end
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
    parameter int SETS   = 128,
    parameter int BEATS  = 8,
    parameter int DATA_W = 64,
    parameter int IDX_W  = 7,
    parameter int BEAT_W = 3
) (
    input  logic                   clk,
    input  logic [IDX_W-1:0]       ra_idx,
    input  logic [BEAT_W-1:0]      ra_beat,
    output logic [1:0][DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]       rb_idx,
    input  logic [BEAT_W-1:0]      rb_beat,
    output logic [1:0][DATA_W-1:0] rb_data,
    input  logic                   we,
    input  logic                   wway,
    input  logic [IDX_W-1:0]       widx,
    input  logic [BEAT_W-1:0]      wbeat,
    input  logic [DATA_W-1:0]      wdata
);
    localparam int DEPTH = SETS * BEATS;

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [DATA_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wway == 1'(w))
                mem_q[{widx, wbeat}] <= wdata;
        end

        assign ra_data[w] = mem_q[{ra_idx, ra_beat}];
        assign rb_data[w] = mem_q[{rb_idx, rb_beat}];
    end
endmodule

// File: rtl/dc_fill_buf.sv
module dc_fill_buf #(
    parameter int BEATS  = 8,
    parameter int DATA_W = 64,
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              we,
    input  logic [BEAT_W-1:0] wbeat,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BEAT_W-1:0] ra_beat,
    output logic [DATA_W-1:0] ra_data,
    input  logic [BEAT_W-1:0] rb_beat,
    output logic [DATA_W-1:0] rb_data
);
    logic [DATA_W-1:0] slot_q [BEATS];

    always_ff @(posedge clk) begin
        if (we) slot_q[wbeat] <= wdata;
    end

    assign ra_data = slot_q[ra_beat];
    assign rb_data = slot_q[rb_beat];
endmodule

// File: rtl/dcache_2way.sv
module dcache_2way #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int LINE_BYTES = 64,
    parameter int SETS       = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              cpu_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ready,
    input  logic              mem_beat_valid,
    input  logic [DATA_W-1:0] mem_beat_data,
    input  logic              mem_beat_cacheable,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    input  logic              wb_ready,
    output logic              st_valid,
    output logic [ADDR_W-1:0] st_addr,
    output logic [DATA_W-1:0] st_data,
    input  logic              st_ready
);
    import dcache_pkg::*;

    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int BEATS  = LINE_BYTES / (DATA_W / 8);
    localparam int BEAT_W = $clog2(BEATS);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    typedef struct packed {
        ctrl_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              vic_way;
        logic              vic_dirty;
        logic [TAG_W-1:0]  vic_tag;
        logic [BEAT_W-1:0] cnt;
        logic              rsp_v;
        logic [DATA_W-1:0] rsp_data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // lookup path
    logic [IDX_W-1:0]       lk_idx;
    logic [TAG_W-1:0]       lk_tag;
    logic [1:0]             way_hit;
    logic                   vic_way, vic_dirty;
    logic [TAG_W-1:0]       vic_tag;
    logic                   hit, hit_way;
    logic [IDX_W-1:0]       cur_idx;
    logic [BEAT_W-1:0]      req_beat, cur_word;

    // state update strobes
    logic                   lru_we, lru_val;
    logic                   dirty_we;
    logic                   inst_we;
    logic                   dw_we, dw_way;
    logic [BEAT_W-1:0]      dw_beat;
    logic [DATA_W-1:0]      dw_data;
    logic                   fb_we;
    logic [1:0][DATA_W-1:0] ra_data, rb_data;
    logic [DATA_W-1:0]      fb_word, fb_cur;

    assign cur_idx  = ctl_q.addr[OFF_W +: IDX_W];
    assign cur_word = ctl_q.addr[BYTE_W +: BEAT_W];
    assign req_beat = req_addr[BYTE_W +: BEAT_W];
    assign lk_idx   = (ctl_q.st == ST_IDLE) ? req_addr[OFF_W +: IDX_W] : cur_idx;
    assign lk_tag   = (ctl_q.st == ST_IDLE) ? req_addr[ADDR_W-1 -: TAG_W]
                                            : ctl_q.addr[ADDR_W-1 -: TAG_W];
    assign hit      = |way_hit;
    assign hit_way  = way_hit[1];

    dc_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_idx    (lk_idx),
        .lk_tag    (lk_tag),
        .way_hit   (way_hit),
        .vic_way   (vic_way),
        .vic_dirty (vic_dirty),
        .vic_tag   (vic_tag),
        .lru_we    (lru_we),
        .lru_idx   (lk_idx),
        .lru_val   (lru_val),
        .dirty_we  (dirty_we),
        .dirty_idx (lk_idx),
        .dirty_way (hit_way),
        .inst_we   (inst_we),
        .inst_idx  (cur_idx),
        .inst_way  (ctl_q.vic_way),
        .inst_tag  (ctl_q.addr[ADDR_W-1 -: TAG_W])
    );

    dc_data_store #(
        .SETS(SETS), .BEATS(BEATS), .DATA_W(DATA_W), .IDX_W(IDX_W), .BEAT_W(BEAT_W)
    ) u_data (
        .clk     (clk),
        .ra_idx  (lk_idx),
        .ra_beat (req_beat),
        .ra_data (ra_data),
        .rb_idx  (cur_idx),
        .rb_beat (ctl_q.cnt),
        .rb_data (rb_data),
        .we      (dw_we),
        .wway    (dw_way),
        .widx    (lk_idx),
        .wbeat   (dw_beat),
        .wdata   (dw_data)
    );

    dc_fill_buf #(.BEATS(BEATS), .DATA_W(DATA_W), .BEAT_W(BEAT_W)) u_fbuf (
        .clk     (clk),
        .we      (fb_we),
        .wbeat   (ctl_q.cnt),
        .wdata   (mem_beat_data),
        .ra_beat (cur_word),
        .ra_data (fb_word),
        .rb_beat (ctl_q.cnt),
        .rb_data (fb_cur)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.rsp_v = 1'b0;
        lru_we      = 1'b0;
        lru_val     = 1'b0;
        dirty_we    = 1'b0;
        inst_we     = 1'b0;
        dw_we       = 1'b0;
        dw_way      = 1'b0;
        dw_beat     = req_beat;
        dw_data     = req_wdata;
        fb_we       = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.addr  = req_addr;
                    ctl_d.wdata = req_wdata;
                    if (hit) begin
                        lru_we  = 1'b1;
                        lru_val = ~hit_way;
                        if (req_we) begin
                            dw_we    = 1'b1;
                            dw_way   = hit_way;
                            dirty_we = 1'b1;
                        end else begin
                            ctl_d.rsp_v    = 1'b1;
                            ctl_d.rsp_data = ra_data[hit_way];
                        end
                    end else if (req_we) begin
                        ctl_d.st = ST_STORE;
                    end else begin
                        ctl_d.st        = ST_REQ;
                        ctl_d.vic_way   = vic_way;
                        ctl_d.vic_dirty = vic_dirty;
                        ctl_d.vic_tag   = vic_tag;
                        ctl_d.cnt       = '0;
                    end
                end
            end
            ST_STORE: begin
                if (st_ready) ctl_d.st = ST_IDLE;
            end
            ST_REQ: begin
                if (mem_rd_ready) ctl_d.st = ST_FILL;
            end
            ST_FILL: begin
                if (mem_beat_valid) begin
                    fb_we     = 1'b1;
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == LAST_BEAT) begin
                        ctl_d.rsp_v    = 1'b1;
                        ctl_d.rsp_data = (ctl_q.cnt == cur_word) ? mem_beat_data : fb_word;
                        ctl_d.st       = mem_beat_cacheable ? ST_XFER : ST_IDLE;
                    end
                end
            end
            ST_XFER: begin
                if (!ctl_q.vic_dirty || wb_ready) begin
                    dw_we     = 1'b1;
                    dw_way    = ctl_q.vic_way;
                    dw_beat   = ctl_q.cnt;
                    dw_data   = fb_cur;
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == LAST_BEAT) begin
                        inst_we  = 1'b1;
                        lru_we   = 1'b1;
                        lru_val  = ~ctl_q.vic_way;
                        ctl_d.st = ST_IDLE;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cpu_ready    = (ctl_q.st == ST_IDLE);
    assign rsp_valid    = ctl_q.rsp_v;
    assign rsp_rdata    = ctl_q.rsp_data;
    assign mem_rd_valid = (ctl_q.st == ST_REQ);
    assign mem_rd_addr  = {ctl_q.addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign wb_valid     = (ctl_q.st == ST_XFER) && ctl_q.vic_dirty;
    assign wb_addr      = {ctl_q.vic_tag, cur_idx, ctl_q.cnt, {BYTE_W{1'b0}}};
    assign wb_data      = rb_data[ctl_q.vic_way];
    assign st_valid     = (ctl_q.st == ST_STORE);
    assign st_addr      = ctl_q.addr;
    assign st_data      = ctl_q.wdata;
endmodule

// File: rtl/dcache_2way_chk.sv
module dcache_2way_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int OFF_W  = 6,
    parameter int BEATS  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              rsp_valid,
    input logic              mem_rd_valid,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_ready,
    input logic              mem_beat_valid,
    input logic              wb_valid,
    input logic [ADDR_W-1:0] wb_addr,
    input logic              wb_ready,
    input logic              st_valid,
    input logic [ADDR_W-1:0] st_addr,
    input logic [DATA_W-1:0] st_data,
    input logic              st_ready
);
    localparam int CNT_W = $clog2(BEATS) + 1;

    logic             fill_pend;
    logic [CNT_W-1:0] beat_cnt;
    logic             last_beat;

    assign last_beat = fill_pend && mem_beat_valid && (beat_cnt == CNT_W'(BEATS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_pend <= 1'b0;
            beat_cnt  <= '0;
        end else if (mem_rd_valid && mem_rd_ready) begin
            fill_pend <= 1'b1;
            beat_cnt  <= '0;
        end else if (last_beat) begin
            fill_pend <= 1'b0;
            beat_cnt  <= '0;
        end else if (fill_pend && mem_beat_valid) begin
            beat_cnt <= beat_cnt + 1'b1;
        end
    end

    p_one_port_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_valid, wb_valid, st_valid}));

    p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid || fill_pend || wb_valid || st_valid) |-> !cpu_ready);

    p_line_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (mem_rd_addr[OFF_W-1:0] == '0));

    p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    p_rsp_after_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |=> rsp_valid);

    p_wb_after_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !fill_pend);

    p_wb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr)));

    p_st_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_addr) && $stable(st_data)));
endmodule

bind dcache_2way dcache_2way_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .OFF_W  (OFF_W),
    .BEATS  (BEATS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_ready      (cpu_ready),
    .rsp_valid      (rsp_valid),
    .mem_rd_valid   (mem_rd_valid),
    .mem_rd_addr    (mem_rd_addr),
    .mem_rd_ready   (mem_rd_ready),
    .mem_beat_valid (mem_beat_valid),
    .wb_valid       (wb_valid),
    .wb_addr        (wb_addr),
    .wb_ready       (wb_ready),
    .st_valid       (st_valid),
    .st_addr        (st_addr),
    .st_data        (st_data),
    .st_ready       (st_ready)
);

// File: tb/dcache_2way_bench.sv
module dcache_2way_bench;
    localparam int BEATS = 8;

    typedef struct packed {
        logic        we;
        logic        nc;
        logic [31:0] addr;
        logic [63:0] wdata;
        logic [1:0]  nfill;
        logic [3:0]  nwb;
        logic        nst;
        logic [31:0] wbline;
        logic [3:0]  req;
    } vec_t;

    // set 5 holds tags 1..6 at line bases 0x2140, 0x4140, ... 0xC140
    localparam vec_t TBL [16] = '{
        '{1'b0, 1'b0, 32'h0000_2148, 64'h0, 2'd1, 4'd0, 1'b0, 32'h0, 4'd2},
        '{1'b0, 1'b0, 32'h0000_2178, 64'h0, 2'd0, 4'd0, 1'b0, 32'h0, 4'd1},
        '{1'b1, 1'b0, 32'h0000_2150, 64'h1111_2222_3333_4444, 2'd0, 4'd0, 1'b0, 32'h0, 4'd5},
        '{1'b0, 1'b0, 32'h0000_2150, 64'h0, 2'd0, 4'd0, 1'b0, 32'h0, 4'd5},
        '{1'b0, 1'b0, 32'h0000_4140, 64'h0, 2'd1, 4'd0, 1'b0, 32'h0, 4'd6},
        '{1'b0, 1'b1, 32'h0000_6158, 64'h0, 2'd1, 4'd0, 1'b0, 32'h0, 4'd8},
        '{1'b0, 1'b0, 32'h0000_2150, 64'h0, 2'd0, 4'd0, 1'b0, 32'h0, 4'd8},
        '{1'b0, 1'b0, 32'h0000_6140, 64'h0, 2'd1, 4'd0, 1'b0, 32'h0, 4'd10},
        '{1'b0, 1'b0, 32'h0000_8168, 64'h0, 2'd1, 4'd8, 1'b0, 32'h0000_2140, 4'd7},
        '{1'b0, 1'b0, 32'h0000_2150, 64'h0, 2'd1, 4'd0, 1'b0, 32'h0, 4'd7},
        '{1'b1, 1'b0, 32'h0000_A148, 64'h5555_6666_7777_8888, 2'd0, 4'd0, 1'b1, 32'h0, 4'd4},
        '{1'b0, 1'b0, 32'h0000_A148, 64'h0, 2'd1, 4'd0, 1'b0, 32'h0, 4'd4},
        '{1'b1, 1'b0, 32'h0000_2160, 64'h9999_AAAA_BBBB_CCCC, 2'd0, 4'd0, 1'b0, 32'h0, 4'd6},
        '{1'b0, 1'b0, 32'h0000_C140, 64'h0, 2'd1, 4'd0, 1'b0, 32'h0, 4'd6},
        '{1'b0, 1'b0, 32'h0000_2160, 64'h0, 2'd0, 4'd0, 1'b0, 32'h0, 4'd6},
        '{1'b0, 1'b0, 32'h0000_2240, 64'h0, 2'd1, 4'd0, 1'b0, 32'h0, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [31:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        cpu_ready, rsp_valid;
    logic [63:0] rsp_rdata;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ready = 1'b0;
    logic        mem_beat_valid = 1'b0;
    logic [63:0] mem_beat_data = '0;
    logic        mem_beat_cacheable = 1'b1;
    logic        wb_valid;
    logic [31:0] wb_addr;
    logic [63:0] wb_data;
    logic        wb_ready = 1'b1;
    logic        st_valid;
    logic [31:0] st_addr;
    logic [63:0] st_data;
    logic        st_ready = 1'b1;

    dcache_2way u_dcache_2way (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .cpu_ready(cpu_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rd_ready(mem_rd_ready),
        .mem_beat_valid(mem_beat_valid), .mem_beat_data(mem_beat_data),
        .mem_beat_cacheable(mem_beat_cacheable),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data), .wb_ready(wb_ready),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready)
    );

    always #10 clk = ~clk;

    int          nchk = 0, nfail = 0, cyc = 0;
    int          fills = 0, wbs = 0, sts = 0;
    int          lb_cyc = 0, first_wb_cyc = 0;
    logic [31:0] first_wb_addr = '0;
    bit          wb_seen = 0, nc_mode = 0, timeout = 0;
    logic [63:0] mem_m    [logic [28:0]];
    logic [63:0] shadow_m [logic [28:0]];

    function automatic logic [63:0] pat(input logic [31:0] a);
        return {~a[31:3], 3'b000, a[31:3], 3'b101};
    endfunction

    function automatic logic [63:0] mem_word(input logic [31:0] a);
        if (mem_m.exists(a[31:3])) return mem_m[a[31:3]];
        return pat(a);
    endfunction

    function automatic logic [63:0] exp_word(input logic [31:0] a);
        if (shadow_m.exists(a[31:3])) return shadow_m[a[31:3]];
        return pat(a);
    endfunction

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd10: return "R10";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // next-level memory responder
    initial begin : responder
        int          phase;
        int          bidx;
        logic [31:0] line;
        logic [31:0] a;
        phase = 0;
        bidx  = 0;
        line  = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                phase = 0;
                mem_rd_ready = 1'b0;
                mem_beat_valid = 1'b0;
            end else begin
                if (phase == 0 && mem_rd_valid) begin
                    mem_rd_ready = 1'b1;
                    line = mem_rd_addr;
                    fills++;
                    phase = 1;
                end else if (phase == 1 || phase == 2) begin
                    mem_rd_ready = 1'b0;
                    if (phase == 1) bidx = 0;
                    else bidx++;
                    if (bidx == BEATS) begin
                        mem_beat_valid = 1'b0;
                        phase = 0;
                    end else begin
                        a = {line[31:6], 3'(bidx), 3'b000};
                        mem_beat_valid = 1'b1;
                        mem_beat_data = mem_word(a);
                        mem_beat_cacheable = !nc_mode;
                        if (bidx == BEATS - 1) lb_cyc = cyc + 1;
                        phase = 2;
                    end
                end
                if (wb_valid) begin
                    mem_m[wb_addr[31:3]] = wb_data;
                    wbs++;
                    if (!wb_seen) begin
                        wb_seen = 1;
                        first_wb_cyc = cyc;
                        first_wb_addr = wb_addr;
                    end
                end
                if (st_valid) begin
                    mem_m[st_addr[31:3]] = st_data;
                    sts++;
                end
            end
        end
    end

    task automatic run_vec(input vec_t v);
        int          f0, w0, s0, rcyc;
        bit          got;
        logic [63:0] rdat, ex;
        string       rn;
        rn = req_name(v.req);
        nc_mode = v.nc;
        f0 = fills; w0 = wbs; s0 = sts;
        wb_seen = 0;
        got = 0; rdat = '0; rcyc = 0;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        req_valid = 1'b1; req_we = v.we; req_addr = v.addr; req_wdata = v.wdata;
        @(negedge clk);
        req_valid = 1'b0;
        if (v.nfill != 0) chk(cpu_ready == 1'b0, "R11 stall on miss", 64'(cpu_ready), 64'd0);
        while (!(cpu_ready && (v.we || got))) begin
            if (rsp_valid && !got) begin
                got = 1; rdat = rsp_rdata; rcyc = cyc;
            end
            @(negedge clk);
        end
        if (v.we) begin
            shadow_m[v.addr[31:3]] = v.wdata;
        end else begin
            ex = exp_word(v.addr);
            chk(rdat == ex, {rn, " load data"}, rdat, ex);
        end
        chk(fills - f0 == int'(v.nfill), {rn, " fill count"}, 64'(fills - f0), 64'(v.nfill));
        chk(wbs - w0 == int'(v.nwb), {rn, " writeback count"}, 64'(wbs - w0), 64'(v.nwb));
        chk(sts - s0 == int'(v.nst), {rn, " store forward count"}, 64'(sts - s0), 64'(v.nst));
        if (v.nfill != 0 && !v.we)
            chk(rcyc == lb_cyc, "R3 response one cycle after last beat", 64'(rcyc), 64'(lb_cyc));
        if (v.nwb != 0) begin
            chk(first_wb_cyc >= lb_cyc, "R7 writeback after fill", 64'(first_wb_cyc), 64'(lb_cyc));
            chk(first_wb_addr == v.wbline, "R7 writeback address", 64'(first_wb_addr), 64'(v.wbline));
        end
    endtask

    task automatic check_idle(input string tag);
        chk(cpu_ready == 1'b1, {tag, " ready"}, 64'(cpu_ready), 64'd1);
        chk({mem_rd_valid, wb_valid, st_valid, rsp_valid} == 4'b0, {tag, " outputs idle"},
            64'({mem_rd_valid, wb_valid, st_valid, rsp_valid}), 64'd0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                check_idle("R9 reset");
                rst_n = 1'b1;
                repeat (2) @(negedge clk);
                for (int i = 0; i < 16; i++) run_vec(TBL[i]);

                // second reset: all lines invalid again (R9)
                @(negedge clk);
                rst_n = 1'b0;
                repeat (2) @(negedge clk);
                check_idle("R9 second reset");
                rst_n = 1'b1;
                @(negedge clk);
                run_vec('{1'b0, 1'b0, 32'h0000_2150, 64'h0, 2'd1, 4'd0, 1'b0, 32'h0, 4'd2});
                run_vec('{1'b0, 1'b0, 32'h0000_2240, 64'h0, 2'd1, 4'd0, 1'b0, 32'h0, 4'd2});
                run_vec('{1'b0, 1'b0, 32'h0000_2240, 64'h0, 2'd0, 4'd0, 1'b0, 32'h0, 4'd1});
                repeat (2) @(negedge clk);
                check_idle("R11 final");
            end
            begin
                repeat (100000) @(posedge clk);
                timeout = 1;
            end
        join_any
        disable fork;
        if (timeout) begin
            nchk++;
            nfail++;
            $display("FAIL R11 watchdog expired actual=hung expected=done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule